// File: doc/BRIEF.md
# USB Bus Suspend and Resume Detector

This block monitors a full-speed USB device link for a lack of bus traffic. A timer is restarted by every start-of-frame strobe. If the timer runs past a programmable number of timing ticks, the block enters suspend. On entry it raises a sticky "suspend started" interrupt flag and sets a separate suspend status bit.

While the link is suspended, a synchronized line-activity input that shows a valid resume level ends the suspend. It then raises a sticky "suspend ended" flag and clears the status bit.

The resume path runs on the always-on clock. Resume detection therefore still works while the core clock enable is low. The inactivity timer advances only while that enable is high.

Software reads the three bits through a small register port. It clears either interrupt flag by writing 1 to the flag's bit position.

Top module: `usb_suspend_detect`

## Requirements
- R1: After reset, both interrupt flags and the suspend status bit read 0.
- R2: If IDLE_TICKS+1 ticks are sampled with no start-of-frame strobe, the suspend status bit and the suspend-started flag are set. Both are visible in the cycle after the clock edge that samples the last tick. IDLE_TICKS ticks alone change nothing.
- R3: A start-of-frame strobe restarts the inactivity count from zero. When a strobe and a tick are sampled in the same cycle, the strobe wins and the tick is not counted.
- R4: While suspended, a high level on line_resume passes through two synchronizer flops. At the third rising edge after the input goes high, the block clears the suspend status bit and sets the suspend-ended flag.
- R5: Resume detection (R4) works with core_clk_en held low.
- R6: While core_clk_en is low, ticks and start-of-frame strobes have no effect on the inactivity count.
- R7: Both flags are sticky. A write with reg_wdata bit 0 set clears the suspend-started flag, and a write with bit 1 set clears the suspend-ended flag. Zero bits leave a flag unchanged, and no write changes the status bit.
- R8: When a flag is set and cleared by a write in the same cycle, the set wins.
- R9: reg_rdata holds bit 0 = suspend-started flag, bit 1 = suspend-ended flag and bit 2 = suspend status. Each bit equals its dedicated output port.
- R10: After suspend ends, the inactivity count starts again from zero. Ticks sampled during suspend are not counted.
- R11: A high line_resume while the link is not suspended has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_seen | input | 1 | One-cycle strobe: start-of-frame token decoded |
| line_resume | input | 1 | Asynchronous: line shows a valid resume/activity level |
| tick | input | 1 | One-cycle timing tick of known period |
| core_clk_en | input | 1 | Core clock enable; low while the core clock is gated |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Write-1-to-clear mask: bit 0 start flag, bit 1 end flag |
| reg_rdata | output | 3 | Read value {status, end flag, start flag} |
| irq_suspend_start | output | 1 | Sticky suspend-started flag |
| irq_suspend_end | output | 1 | Sticky suspend-ended flag |
| bus_suspended | output | 1 | Suspend status bit |

## Verification
The assertions assume that sof_seen and tick are synchronous single-cycle pulses. They also assume that core_clk_en is lowered only while the link is suspended, so the timer freeze is observed only in a state that software may legally reach. The stimulus follows these assumptions. Every pulse is driven for exactly one edge at a falling clock edge, and the enable is dropped only after suspend has been reported. The enable is raised again only after a resume. line_resume is held for several cycles, so that the synchronizer latency is exercised under both settings of the clock enable.

// File: rtl/usbsr_pkg.sv
// Package: shared register bit positions for the suspend detector.
// Assumes a three-bit read word and a two-bit clear mask.
package usbsr_pkg;
    localparam int REG_W    = 3;
    localparam int CLR_W    = 2;
    localparam int BIT_SB   = 0;  // suspend-started flag
    localparam int BIT_SE   = 1;  // suspend-ended flag
    localparam int BIT_SUSP = 2;  // suspend status
endpackage

// File: rtl/usbsr_sync.sv
// Module: multi-stage flop synchronizer for one asynchronous bit.
// Assumes the destination clock is the always-on clock; STAGES >= 2.
module usbsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/usbsr_idle_timer.sv
// Module: bus inactivity timer. It counts ticks while the core clock
// is enabled and the link is not suspended. A start-of-frame strobe
// restarts it, and suspend holds it at zero, so it restarts on exit.
// Assumes tick and sof are single-cycle synchronous pulses.
module usbsr_idle_timer #(
    parameter int IDLE_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_clk_en,
    input  logic tick,
    input  logic sof,
    input  logic suspended,
    output logic expire
);
    localparam int CNT_W = (IDLE_TICKS < 1) ? 1 : $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_TICKS);

    logic [CNT_W-1:0] cnt;
    logic             restart;
    logic             adv;

    assign restart = suspended | (core_clk_en & sof);
    assign adv     = core_clk_en & tick & ~restart;
    assign expire  = adv & (cnt == LIMIT);

    // Count idle ticks, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (restart)             cnt <= '0;
        else if (adv && cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);
    p_sof_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && sof) |=> cnt == '0);
    p_gated_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && !suspended) |=> cnt == $past(cnt));
    p_susp_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> cnt == '0);
endmodule

// File: rtl/usbsr_flags.sv
// Module: suspend status bit and the two sticky interrupt flags with
// write-1-to-clear. Runs on the always-on clock, so the resume event
// is seen even with the core clock gated. Set has priority over clear.
module usbsr_flags
    import usbsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             line_act,
    input  logic             wr,
    input  logic [CLR_W-1:0] wdata,
    output logic             suspended,
    output logic             flag_sb,
    output logic             flag_se
);
    logic resume_evt;

    assign resume_evt = suspended & line_act;

    // Track suspend state: entered on expiry, left on resume.
    always_ff @(posedge clk) begin
        if (!rst_n)          suspended <= 1'b0;
        else if (resume_evt) suspended <= 1'b0;
        else if (expire)     suspended <= 1'b1;
    end

    // Sticky suspend-started flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_sb <= 1'b0;
        else if (expire)               flag_sb <= 1'b1;
        else if (wr && wdata[BIT_SB])  flag_sb <= 1'b0;
    end

    // Sticky suspend-ended flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_se <= 1'b0;
        else if (resume_evt)           flag_se <= 1'b1;
        else if (wr && wdata[BIT_SE])  flag_se <= 1'b0;
    end

    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (suspended && flag_sb));
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(expire));
    p_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && line_act) |=> (!suspended && flag_se));
    p_sb_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_sb && !(wr && wdata[BIT_SB])) |=> flag_sb);
    p_se_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_se && !(wr && wdata[BIT_SE])) |=> flag_se);
    p_idle_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && !expire) |=> !suspended);
endmodule

// File: rtl/usb_suspend_detect.sv
// Module: top of the USB suspend/resume detector. It joins the line
// synchronizer, the inactivity timer and the flag register, and it
// exposes the read word. Assumes software gates the core clock only
// while suspended; the timer honours core_clk_en as a clock enable.
module usb_suspend_detect
    import usbsr_pkg::*;
#(
    parameter int IDLE_TICKS  = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_seen,
    input  logic             line_resume,
    input  logic             tick,
    input  logic             core_clk_en,
    input  logic             reg_wr,
    input  logic [CLR_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_suspend_start,
    output logic             irq_suspend_end,
    output logic             bus_suspended
);
    logic line_act;
    logic expire;
    logic susp;
    logic f_sb;
    logic f_se;

    usbsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_resume),
        .q_sync  (line_act)
    );

    usbsr_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_clk_en (core_clk_en),
        .tick        (tick),
        .sof         (sof_seen),
        .suspended   (susp),
        .expire      (expire)
    );

    usbsr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .line_act  (line_act),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .suspended (susp),
        .flag_sb   (f_sb),
        .flag_se   (f_se)
    );

    // Assemble the read word from the flag register state.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[BIT_SB]   = f_sb;
        reg_rdata[BIT_SE]   = f_se;
        reg_rdata[BIT_SUSP] = susp;
    end

    assign irq_suspend_start = f_sb;
    assign irq_suspend_end   = f_se;
    assign bus_suspended     = susp;

    p_rdata_ports_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata == {bus_suspended, irq_suspend_end, irq_suspend_start});
endmodule

// File: tb/usb_suspend_detect_tb.sv
module usb_suspend_detect_tb;
    localparam int IT = 30;
    localparam logic [3:0] OP_TICKS = 4'd0, OP_SOF = 4'd1, OP_RES = 4'd2,
                           OP_CLR = 4'd3, OP_GATE = 4'd4;
    localparam int NV = 22;
    // Vector fields: [19:16] requirement, [15:12] op, [11:4] arg,
    // [2:0] expected {status, end flag, start flag}.
    localparam logic [19:0] VEC [NV] = '{
        {4'd2,  OP_TICKS, 8'd30, 4'b0000}, // R2 limit not yet passed
        {4'd2,  OP_TICKS, 8'd1,  4'b0101}, // R2 enter suspend
        {4'd7,  OP_CLR,   8'd1,  4'b0100}, // R7 clear start flag
        {4'd4,  OP_RES,   8'd0,  4'b0010}, // R4 resume
        {4'd10, OP_TICKS, 8'd30, 4'b0010}, // R10 restart from zero
        {4'd3,  OP_SOF,   8'd0,  4'b0010}, // R3 sof
        {4'd3,  OP_TICKS, 8'd30, 4'b0010}, // R3 count restarted
        {4'd2,  OP_TICKS, 8'd1,  4'b0111}, // R2 second entry
        {4'd7,  OP_CLR,   8'd3,  4'b0100}, // R7 clear both
        {4'd6,  OP_GATE,  8'd0,  4'b0100}, // R6 gate core clock
        {4'd6,  OP_TICKS, 8'd40, 4'b0100}, // R6 gated ticks
        {4'd6,  OP_SOF,   8'd0,  4'b0100}, // R6 gated sof
        {4'd5,  OP_RES,   8'd0,  4'b0010}, // R5 resume while gated
        {4'd6,  OP_TICKS, 8'd40, 4'b0010}, // R6 gated, not counted
        {4'd6,  OP_GATE,  8'd1,  4'b0010}, // R6 ungate
        {4'd7,  OP_CLR,   8'd0,  4'b0010}, // R7 zero mask no effect
        {4'd6,  OP_TICKS, 8'd30, 4'b0010}, // R6 nothing accumulated
        {4'd2,  OP_TICKS, 8'd1,  4'b0111}, // R2 enter
        {4'd7,  OP_CLR,   8'd3,  4'b0100}, // R7 status untouched
        {4'd10, OP_TICKS, 8'd15, 4'b0100}, // R10 ticks in suspend
        {4'd4,  OP_RES,   8'd0,  4'b0010}, // R4 resume
        {4'd7,  OP_CLR,   8'd2,  4'b0000}  // R7 clear end flag
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof_seen = 1'b0;
    logic       line_resume = 1'b0;
    logic       tick = 1'b0;
    logic       core_clk_en = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_wdata = '0;
    logic [2:0] reg_rdata;
    logic       irq_suspend_start, irq_suspend_end, bus_suspended;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    usb_suspend_detect #(.IDLE_TICKS(IT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sof_seen(sof_seen),
        .line_resume(line_resume), .tick(tick), .core_clk_en(core_clk_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_suspend_start(irq_suspend_start),
        .irq_suspend_end(irq_suspend_end), .bus_suspended(bus_suspended)
    );

    task automatic chk(input int req, input logic [2:0] exp, input string what);
        logic [2:0] ports;
        ports = {bus_suspended, irq_suspend_end, irq_suspend_start};
        n_tests++;
        if (reg_rdata !== exp || ports !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: rdata=%b ports=%b expected=%b",
                     req, what, reg_rdata, ports, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic do_sof();
        @(negedge clk) sof_seen = 1'b1;
        @(negedge clk) sof_seen = 1'b0;
    endtask

    task automatic do_resume();
        @(negedge clk) line_resume = 1'b1;
        repeat (3) @(negedge clk);
        line_resume = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_clr(input logic [1:0] m);
        @(negedge clk) begin reg_wr = 1'b1; reg_wdata = m; end
        @(negedge clk) begin reg_wr = 1'b0; reg_wdata = '0; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, 3'b000, "reset state");  // R1 and R9

        for (int v = 0; v < NV; v++) begin
            logic [19:0] e;
            e = VEC[v];
            case (e[15:12])
                OP_TICKS: do_ticks(int'(e[11:4]));
                OP_SOF:   do_sof();
                OP_RES:   do_resume();
                OP_CLR:   do_clr(e[5:4]);
                default:  begin @(negedge clk) core_clk_en = e[4]; @(negedge clk); end
            endcase
            chk(int'(e[19:16]), e[2:0], $sformatf("vector %0d", v));
        end

        // R11: line activity while not suspended is ignored
        @(negedge clk) line_resume = 1'b1;
        repeat (5) @(negedge clk);
        line_resume = 1'b0;
        repeat (3) @(negedge clk);
        chk(11, 3'b000, "line high while active");
        do_ticks(IT);
        chk(11, 3'b000, "count not disturbed");

        // R3: sof and tick in the same cycle, sof wins
        @(negedge clk) begin tick = 1'b1; sof_seen = 1'b1; end
        @(negedge clk) begin tick = 1'b0; sof_seen = 1'b0; end
        chk(3, 3'b000, "sof beats tick at limit");
        do_ticks(IT);
        chk(3, 3'b000, "full count after same-cycle sof");

        // R8: expiry and clear of the start flag in the same cycle
        @(negedge clk) begin tick = 1'b1; reg_wr = 1'b1; reg_wdata = 2'b01; end
        @(negedge clk) begin tick = 1'b0; reg_wr = 1'b0; reg_wdata = '0; end
        chk(8, 3'b101, "set beats clear on start flag");
        do_clr(2'b01);
        chk(7, 3'b100, "start flag cleared");

        // R4 latency and R8 on the end flag
        @(negedge clk) line_resume = 1'b1;
        @(negedge clk);
        chk(4, 3'b100, "one edge after line high");
        @(negedge clk) begin reg_wr = 1'b1; reg_wdata = 2'b10; end
        chk(4, 3'b100, "two edges after line high");
        @(negedge clk) begin reg_wr = 1'b0; reg_wdata = '0; end
        chk(8, 3'b010, "third edge resumes, set beats clear");
        line_resume = 1'b0;
        repeat (3) @(negedge clk);
        do_clr(2'b10);
        chk(7, 3'b000, "end flag cleared");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule